// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block raises an interrupt at a fixed, repeating period derived from one of three timebase sources. All sources arrive as one-cycle clock-enable ticks inside a single system clock domain. They are a slow real-time oscillator tick, a watchdog oscillator tick, and an internally generated tick at one quarter of the system clock. A static select input picks the source. A separate override input forces the real-time tick whenever that oscillator also drives the system clock.

Selected ticks advance a free-running 15-bit prescaler. A 3-bit rate value N chooses which prescaler tap produces an event, so that one event occurs every 2^(8+N) ticks. Each delivered event gives a one-cycle pulse and sets a sticky request flag, which an acknowledge input clears. A new rate value waits for the next event before it applies, so no period is cut short.

A wake input opens a blanking window of fixed length. Events that fall inside the window are thrown away rather than deferred. This models the settling time after a wake-up, during which short periods lose interrupts.

Top module: `pit_timer`

## Requirements
- R1: A synchronous active-high reset clears the prescaler, the pulse, the flag, the blanking window and both rate registers (rate 0). After reset, the first event needs exactly 256 selected ticks.
- R2: With active rate N (0..7), an event occurs on every selected tick that brings the tick total since reset to a multiple of 2^(8+N). The total is counted modulo 2^15.
- R3: Source select encoding: 2'b00 is the real-time tick, 2'b01 is the watchdog tick, and 2'b10 and 2'b11 are the quarter-rate system tick. The quarter-rate tick is active in the 4th cycle after reset and in every 4th cycle after that.
- R4: While the override input is high, the real-time tick is used whatever the select value.
- R5: `irqPulse` is high for exactly one cycle. It rises in the cycle after the clock edge on which the counting tick is taken.
- R6: `irqFlag` sets together with `irqPulse` and stays set until a cycle with `ack` high. If an event and `ack` fall in the same cycle, the flag stays set.
- R7: A rate written with `rateWr` takes effect only at the next event, and the prescaler keeps counting. A write in the same cycle as an event governs the period that starts with that event.
- R8: The cycle in which `wake` is high and the 1024 cycles after it are blanked. An event in a blanked cycle produces no pulse, does not set the flag, and is not delivered later. A new `wake` restarts the window.
- R9: Ticks on inputs that are not selected do not advance the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| srcSel | input | 2 | Timebase source select (static) |
| rtcIsSysClk | input | 1 | Forces the real-time tick as the timebase |
| rtcTick | input | 1 | Real-time oscillator tick enable |
| wdtTick | input | 1 | Watchdog oscillator tick enable |
| rateWr | input | 1 | Write strobe for the rate value |
| rateIn | input | 3 | Rate value N, period 2^(8+N) ticks |
| ack | input | 1 | Clears the request flag |
| wake | input | 1 | Starts or restarts the blanking window |
| irqPulse | output | 1 | One-cycle interrupt event |
| irqFlag | output | 1 | Sticky interrupt request |

## Verification
There are two collision cases: an acknowledge landing in the same cycle as an event, and a rate write landing in the same cycle as an event. The bench knows from its own tick count which cycle will complete a period. It drives `ack` in exactly that cycle and expects the flag to stay set. A rate write placed on an event cycle must shape the very next period, while a write placed elsewhere must wait one full period. Wake-ups are placed so that events at rates 0 and 2 fall both inside and just outside the blanking window.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int RATE_W      = 3;
  localparam int MIN_TAP     = 8;
  localparam int NUM_RATES   = 1 << RATE_W;
  localparam int CNT_W       = MIN_TAP + NUM_RATES - 1;
  localparam int WAKE_CYCLES = 1024;
  localparam int WAKE_W      = $clog2(WAKE_CYCLES + 1);
  localparam int SYS_DIV_W   = 2;

  typedef struct packed {
    logic [RATE_W-1:0] tap;
  } pitCtrl_t;
endpackage

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int P_CNT_W   = CNT_W,
  parameter int P_MIN_TAP = MIN_TAP,
  parameter int P_RATES   = NUM_RATES,
  parameter int P_DIV_W   = SYS_DIV_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] srcSel,
  input  logic       rtcIsSysClk,
  input  logic       rtcTick,
  input  logic       wdtTick,
  input  pitCtrl_t   ctrl,
  output logic       evtRaw
);
  localparam logic [P_DIV_W-1:0] DIV_LAST = '1;

  logic [P_DIV_W-1:0] sysPhase;
  logic               sysTick;
  logic               tick;
  logic [P_CNT_W-1:0] cnt;
  logic [P_CNT_W-1:0] cntNext;
  logic [P_CNT_W-1:0] tapMask [P_RATES];

  // quarter-rate system tick, free running
  always_ff @(posedge clk) begin
    if (rst) sysPhase <= '0;
    else     sysPhase <= sysPhase + 1'b1;
  end
  assign sysTick = (sysPhase == DIV_LAST);

  // source mux (R3, R4, R9)
  always_comb begin
    if (rtcIsSysClk) tick = rtcTick;
    else begin
      unique case (srcSel)
        2'b00:   tick = rtcTick;
        2'b01:   tick = wdtTick;
        default: tick = sysTick;
      endcase
    end
  end

  // one low-bit mask per prescaler tap
  for (genvar g = 0; g < P_RATES; g++) begin : g_tap
    localparam logic [P_CNT_W:0] LIM =
      ((P_CNT_W+1)'(1) << (P_MIN_TAP + g)) - (P_CNT_W+1)'(1);
    assign tapMask[g] = LIM[P_CNT_W-1:0];
  end

  assign cntNext = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cntNext;
  end

  assign evtRaw = tick && ((cntNext & tapMask[ctrl.tap]) == '0);
endmodule

// File: rtl/pit_control.sv
module pit_control
  import pit_pkg::*;
#(
  parameter int P_RATE_W = RATE_W,
  parameter int P_WAKE   = WAKE_CYCLES,
  parameter int P_WAKE_W = WAKE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rateWr,
  input  logic [P_RATE_W-1:0] rateIn,
  input  logic                ack,
  input  logic                wake,
  input  logic                evtRaw,
  output pitCtrl_t            ctrl,
  output logic                irqPulse,
  output logic                irqFlag,
  output logic                wakeBusy
);
  localparam logic [P_WAKE_W-1:0] WAKE_LOAD = P_WAKE_W'(P_WAKE);

  logic [P_RATE_W-1:0] pendRate;
  logic [P_RATE_W-1:0] actRate;
  logic [P_WAKE_W-1:0] wakeCnt;
  logic                blank;
  logic                deliver;

  assign wakeBusy = (wakeCnt != '0);
  assign blank    = wake || wakeBusy;
  assign deliver  = evtRaw && !blank;

  // rate registers: staged write, applied on an event (R7)
  always_ff @(posedge clk) begin
    if (rst) begin
      pendRate <= '0;
      actRate  <= '0;
    end else begin
      if (rateWr) pendRate <= rateIn;
      if (evtRaw) actRate  <= rateWr ? rateIn : pendRate;
    end
  end

  // wake-up blanking window (R8)
  always_ff @(posedge clk) begin
    if (rst)           wakeCnt <= '0;
    else if (wake)     wakeCnt <= WAKE_LOAD;
    else if (wakeBusy) wakeCnt <= wakeCnt - 1'b1;
  end

  // pulse and sticky flag (R5, R6)
  always_ff @(posedge clk) begin
    if (rst) begin
      irqPulse <= 1'b0;
      irqFlag  <= 1'b0;
    end else begin
      irqPulse <= deliver;
      irqFlag  <= deliver || (irqFlag && !ack);
    end
  end

  assign ctrl.tap = actRate;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        srcSel,
  input  logic              rtcIsSysClk,
  input  logic              rtcTick,
  input  logic              wdtTick,
  input  logic              rateWr,
  input  logic [RATE_W-1:0] rateIn,
  input  logic              ack,
  input  logic              wake,
  output logic              irqPulse,
  output logic              irqFlag
);
  pitCtrl_t ctrl;
  logic     evtRaw;
  logic     wakeBusy;

  pit_datapath u_dp (
    .clk        (clk),
    .rst        (rst),
    .srcSel     (srcSel),
    .rtcIsSysClk(rtcIsSysClk),
    .rtcTick    (rtcTick),
    .wdtTick    (wdtTick),
    .ctrl       (ctrl),
    .evtRaw     (evtRaw)
  );

  pit_control u_ctl (
    .clk     (clk),
    .rst     (rst),
    .rateWr  (rateWr),
    .rateIn  (rateIn),
    .ack     (ack),
    .wake    (wake),
    .evtRaw  (evtRaw),
    .ctrl    (ctrl),
    .irqPulse(irqPulse),
    .irqFlag (irqFlag),
    .wakeBusy(wakeBusy)
  );
endmodule

// File: rtl/pit_timer_checker.sv
module pit_timer_checker (
  input logic clk,
  input logic rst,
  input logic ack,
  input logic wake,
  input logic wakeBusy,
  input logic irqPulse,
  input logic irqFlag
);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    irqPulse |=> !irqPulse);

  a_r6_flag_with_pulse: assert property (@(posedge clk) disable iff (rst)
    irqPulse |-> irqFlag);

  a_r6_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (irqFlag && !ack) |=> irqFlag);

  a_r6_flag_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irqFlag) |-> irqPulse);

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ack |=> (!irqFlag || irqPulse));

  a_r8_blanked: assert property (@(posedge clk) disable iff (rst)
    (wake || wakeBusy) |=> !irqPulse);
endmodule

bind pit_timer pit_timer_checker i_chk (
  .clk     (clk),
  .rst     (rst),
  .ack     (ack),
  .wake    (wake),
  .wakeBusy(wakeBusy),
  .irqPulse(irqPulse),
  .irqFlag (irqFlag)
);

// File: tb/test_pit_timer.sv
module test_pit_timer;
  localparam int CLK_PER = 10;
  localparam int WAKE_LEN = 1024;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] srcSel;
  logic rtcIsSysClk, rtcTick, wdtTick, rateWr, ack, wake;
  logic [2:0] rateIn;
  logic irqPulse, irqFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state, built from the requirements
  int tickTot, sysPh, actM, pendM, wakeLeft;
  bit flagM;

  logic [1:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PER/2) clk = ~clk;

  pit_timer i_pit_timer (
    .clk(clk), .rst(rst), .srcSel(srcSel), .rtcIsSysClk(rtcIsSysClk),
    .rtcTick(rtcTick), .wdtTick(wdtTick), .rateWr(rateWr), .rateIn(rateIn),
    .ack(ack), .wake(wake), .irqPulse(irqPulse), .irqFlag(irqFlag)
  );

  // monitor: pops one expectation per cycle, samples after the edge
  always @(posedge clk) begin
    #(CLK_PER/4);
    if (expQ.size() > 0) begin
      logic [1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if ({irqPulse, irqFlag} !== e) begin
        errors++;
        $display("FAIL %s pulse/flag actual %b expected %b at %0t", t,
                 {irqPulse, irqFlag}, e, $time);
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1; rtcTick = 0; wdtTick = 0; rateWr = 0; rateIn = 0;
    ack = 0; wake = 0;
    repeat (3) @(negedge clk);
    tickTot = 0; sysPh = 0; actM = 0; pendM = 0; wakeLeft = 0; flagM = 0;
    rst = 1'b0;
    // R1: outputs cleared while and after reset
    checks++;
    if ({irqPulse, irqFlag} !== 2'b00) begin
      errors++;
      $display("FAIL R1 reset outputs actual %b expected 00", {irqPulse, irqFlag});
    end
  endtask

  // driver: one cycle of stimulus plus its expected outcome
  task automatic step(input logic rT, input logic wT, input logic wr,
                      input logic [2:0] rv, input logic ak, input logic wk,
                      input bit ackOnEvt, input string tag);
    bit tk, ev, blank, pulse, akE;
    int per;
    if (rtcIsSysClk) tk = rT;
    else if (srcSel == 2'b00) tk = rT;
    else if (srcSel == 2'b01) tk = wT;
    else tk = (sysPh == 3);
    sysPh = (sysPh + 1) % 4;
    per = 1 << (8 + actM);
    ev = tk && (((tickTot + 1) % per) == 0);
    if (tk) tickTot = (tickTot + 1) % 32768;
    blank = wk || (wakeLeft > 0);
    if (wk) wakeLeft = WAKE_LEN;
    else if (wakeLeft > 0) wakeLeft--;
    akE = ak || (ackOnEvt && ev);
    pulse = ev && !blank;
    if (pulse) flagM = 1;
    else if (akE) flagM = 0;
    if (ev) actM = wr ? int'(rv) : pendM;
    if (wr) pendM = int'(rv);
    rtcTick = rT; wdtTick = wT; rateWr = wr; rateIn = rv; ack = akE; wake = wk;
    expQ.push_back({pulse, flagM});
    tagQ.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    rtcTick = 0; wdtTick = 0; rateWr = 0; ack = 0; wake = 0;
  endtask

  task automatic run_rtc(input int n, input bit ackEvt, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, ackEvt, tag);
  endtask

  initial begin
    srcSel = 2'b00; rtcIsSysClk = 0;
    @(negedge clk);
    // R1, R2, R5: real-time tick every cycle, rate 0
    do_reset();
    run_rtc(300, 0, "R2");
    step(1, 0, 0, 0, 1, 0, 0, "R6");           // plain ack clears
    run_rtc(300, 0, "R5");
    // R6: ack coinciding with the event keeps the flag
    run_rtc(400, 1, "R6");
    // R7: deferred write away from an event, then write on an event cycle
    do_reset();
    for (int i = 0; i < 100; i++) step(1, 0, (i == 50), 3'd2, 0, 0, 0, "R7");
    run_rtc(1500, 0, "R7");
    for (int i = 0; i < 1300; i++) step(1, 0, 0, 0, 0, 0, 0, "R7");
    // tickTot now known; write rate 0 exactly on the next rate-2 event
    while (((tickTot + 1) % 1024) != 0) step(1, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 0, 1, 3'd0, 0, 0, 0, "R7");
    run_rtc(600, 0, "R7");
    // R8: wake blanking at rate 0 and rate 2, plus restart
    do_reset();
    run_rtc(200, 0, "R8");
    step(1, 0, 0, 0, 1, 1, 0, "R8");
    run_rtc(700, 0, "R8");
    step(1, 0, 0, 0, 0, 1, 0, "R8");           // restart window
    run_rtc(1400, 0, "R8");
    step(1, 0, 1, 3'd2, 1, 0, 0, "R8");
    run_rtc(300, 0, "R8");
    while (((tickTot + 1) % 1024) != 1000) step(1, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 0, 0, 0, 0, 1, 0, "R8");
    run_rtc(2100, 0, "R8");
    // R3, R9: watchdog source with real-time noise
    do_reset();
    srcSel = 2'b01;
    for (int i = 0; i < 900; i++) step(1, (i % 3 == 0), 0, 0, 0, 0, 0, "R9");
    // R3: quarter-rate system tick, both encodings
    do_reset();
    srcSel = 2'b10;
    for (int i = 0; i < 1100; i++) step(1, 1, 0, 0, 0, 0, 0, "R3");
    do_reset();
    srcSel = 2'b11;
    for (int i = 0; i < 1100; i++) step(0, 1, 0, 0, 0, 0, 0, "R3");
    // R4: override forces the real-time tick
    do_reset();
    srcSel = 2'b10; rtcIsSysClk = 1;
    for (int i = 0; i < 800; i++) step((i % 2 == 0), 1, 0, 0, 0, 0, 0, "R4");
    rtcIsSysClk = 0; srcSel = 2'b00;
    // R2: longest period, rate 7, counter keeps running through the change
    do_reset();
    step(1, 0, 1, 3'd7, 0, 0, 0, "R2");
    run_rtc(33000, 1, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule